// File: doc/BRIEF.md
# Multi-channel prescaled timer unit

A bus-attached peripheral holding one free-running prescaler and a set of identical down-counting timers. The prescaler divides the bus clock and hands the resulting tick to every timer. Each timer counts that tick down while enabled. When it passes zero, it either reloads for periodic operation or stops for single-shot operation. In both cases it sets a level-held pending flag and can emit a one-cycle interrupt pulse.

Software reaches the block through an APB-style register port. There are two global registers for the prescaler and a read-only configuration word. Each timer has three registers: counter, reload and control. A build-time option chooses the interrupt routing. Either every timer drives its own line, offset from a base number, or all timers share the base line.

Top module: `mtimer_unit`

## Requirements
- R1: After reset every readable register returns zero except the configuration word, the prescaler reload is zero (a tick every clock), and `irq_o` is all low.
- R2: The prescaler count decrements every clock. When it is zero it raises a tick for that cycle and reloads from the scaler reload register, so a tick arrives every (scaler reload + 1) clocks. A bus write to the scaler value register sets the count directly.
- R3: A timer counter decrements by one on each prescaler tick while its enable bit (control bit 0) is set. With enable clear, the counter holds its value.
- R4: With restart (control bit 1) set, a timer that receives a tick at zero reloads from its reload register, giving a period of (reload + 1) ticks.
- R5: With restart clear, a timer that receives a tick at zero stays at zero and clears its own enable bit.
- R6: Writing control with the load bit (bit 2) set copies the reload register into the counter in the same cycle as the write. That tick is ignored, and the load bit always reads back as zero.
- R7: The pending bit (control bit 4) is set when an enabled timer receives a tick at zero. Writing one to it clears it and writing zero leaves it unchanged. A set in the same cycle as a clear wins.
- R8: One clock after an underflow, if interrupt enable (control bit 3) was set, a one-cycle pulse appears on `irq_o` bit BASE_IRQ+i for timer i in separate mode, or on bit BASE_IRQ for every timer in shared mode. With interrupt enable clear, no pulse appears but pending is still set.
- R9: Counter and reload registers hold CNT_W bits. Writes keep only the low CNT_W bits, so writing all ones reads back as the width mask.
- R10: Control bits 0, 1, 3, 5 and 6 read back as last written.
- R11: The address map is as follows. `paddr_i[7:4]` selects the region: 0 is global, and k is timer k-1. `paddr_i[3:2]` selects the register: global 0/1/2 are scaler value, scaler reload and configuration; timer 0/1/2 are counter, reload and control. Other addresses read as zero. The configuration word carries the timer count in bits 2:0, BASE_IRQ in bits 7:3, the separate-interrupt flag in bit 8 and the freeze flag in bit 9. A write takes effect at the clock edge where `psel_i`, `penable_i` and `pwrite_i` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Peripheral select |
| penable_i | input | 1 | Access phase |
| pwrite_i | input | 1 | Write when high |
| paddr_i | input | 8 | Byte address |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | IRQ_LINES | Interrupt pulses |

## Verification
The in-RTL assertions check a set of per-cycle rules on every cycle. The prescaler must reload on its tick and count down otherwise. A disabled counter must hold its value, and an underflow must either reload the counter or stop the timer. Pending must rise on underflow, an interrupt pulse must never appear without pending, and in shared mode no line other than the base line may toggle. The bench scenarios cover what no single-cycle rule can show: the end-to-end interrupt rates for several prescaler and reload settings, single-shot completion, the effect of the interrupt-enable gate, width masking and the write-one-to-clear behaviour. A behavioural model running in parallel compares the read data and interrupt lines on every clock.

// File: rtl/tu_pkg.sv
package tu_pkg;
  // control bit positions
  localparam int CB_EN = 0;
  localparam int CB_RS = 1;
  localparam int CB_LD = 2;
  localparam int CB_IE = 3;
  localparam int CB_IP = 4;
  localparam int CB_CH = 5;
  localparam int CB_DH = 6;
  localparam int CTL_W = 7;

  // register select within a region (paddr[3:2])
  localparam logic [1:0] TS_CNT  = 2'd0;
  localparam logic [1:0] TS_RLD  = 2'd1;
  localparam logic [1:0] TS_CTL  = 2'd2;
  localparam logic [1:0] GS_SVAL = 2'd0;
  localparam logic [1:0] GS_SRLD = 2'd1;
  localparam logic [1:0] GS_CFG  = 2'd2;
endpackage

// File: rtl/tu_prescaler.sv
module tu_prescaler #(
  parameter int SCL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             val_we_i,
  input  logic             rld_we_i,
  input  logic [SCL_W-1:0] wdata_i,
  output logic [SCL_W-1:0] val_o,
  output logic [SCL_W-1:0] rld_o,
  output logic             tick_o
);
  logic [SCL_W-1:0] val_q, rld_q;

  assign tick_o = (val_q == '0);
  assign val_o  = val_q;
  assign rld_o  = rld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      rld_q <= '0;
    end else begin
      if (val_we_i)    val_q <= wdata_i;
      else if (tick_o) val_q <= rld_q;
      else             val_q <= val_q - 1'b1;
      if (rld_we_i)    rld_q <= wdata_i;
    end
  end

  a_r2_reload_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !val_we_i) |=> (val_o == $past(rld_o)));
  a_r2_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_o && !val_we_i) |=> (val_o == $past(val_o) - 1'b1));
endmodule

// File: rtl/tu_channel.sv
module tu_channel import tu_pkg::*; #(
  parameter  int CNT_W = 16,
  localparam int WD    = (CNT_W > CTL_W) ? CNT_W : CTL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cnt_we_i,
  input  logic             rld_we_i,
  input  logic             ctl_we_i,
  input  logic [WD-1:0]    wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rld_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, rld_q;
  logic en_q, rs_q, ie_q, ip_q, ch_q, dh_q, pulse_q;
  logic load, uf;

  assign load = ctl_we_i && wdata_i[CB_LD];
  // bus access to the counter overrides the tick in that cycle
  assign uf   = tick_i && en_q && (cnt_q == '0) && !cnt_we_i && !load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      rld_q   <= '0;
      en_q    <= 1'b0;
      rs_q    <= 1'b0;
      ie_q    <= 1'b0;
      ip_q    <= 1'b0;
      ch_q    <= 1'b0;
      dh_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (cnt_we_i)           cnt_q <= wdata_i[CNT_W-1:0];
      else if (load)          cnt_q <= rld_q;
      else if (tick_i && en_q) begin
        if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
        else if (rs_q)        cnt_q <= rld_q;
      end
      if (rld_we_i)           rld_q <= wdata_i[CNT_W-1:0];
      if (ctl_we_i) begin
        en_q <= wdata_i[CB_EN];
        rs_q <= wdata_i[CB_RS];
        ie_q <= wdata_i[CB_IE];
        ch_q <= wdata_i[CB_CH];
        dh_q <= wdata_i[CB_DH];
      end else if (uf && !rs_q) begin
        en_q <= 1'b0;
      end
      if (uf)                               ip_q <= 1'b1;
      else if (ctl_we_i && wdata_i[CB_IP])  ip_q <= 1'b0;
      pulse_q <= uf && ie_q;
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
  assign ctl_o = {dh_q, ch_q, ip_q, ie_q, 1'b0, rs_q, en_q};
  assign irq_o = pulse_q;

  a_r3_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_o[CB_EN] && !cnt_we_i && !load) |=> $stable(cnt_o));
  a_r4_periodic_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf && ctl_o[CB_RS]) |=> (cnt_o == $past(rld_o)));
  a_r5_oneshot_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf && !ctl_o[CB_RS] && !ctl_we_i) |=> (!ctl_o[CB_EN] && cnt_o == '0));
  a_r6_load_copies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !cnt_we_i) |=> (cnt_o == $past(rld_o)));
  a_r7_pend_on_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf |=> ctl_o[CB_IP]);
  a_r8_pulse_with_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ctl_o[CB_IP] && $past(ctl_o[CB_IE])));
endmodule

// File: rtl/tu_irq_route.sv
module tu_irq_route #(
  parameter int N_TIMERS  = 4,
  parameter int IRQ_LINES = 16,
  parameter int BASE_IRQ  = 6,
  parameter bit SEP_IRQ   = 1'b1
) (
  input  logic [N_TIMERS-1:0]  evt_i,
  output logic [IRQ_LINES-1:0] irq_o
);
  generate
    if (SEP_IRQ) begin : g_sep
      always_comb begin
        irq_o = '0;
        irq_o[BASE_IRQ +: N_TIMERS] = evt_i;
      end
    end else begin : g_shared
      always_comb begin
        irq_o = '0;
        irq_o[BASE_IRQ] = |evt_i;
      end
    end
  endgenerate
endmodule

// File: rtl/mtimer_unit.sv
module mtimer_unit import tu_pkg::*; #(
  parameter int N_TIMERS    = 4,
  parameter int CNT_W       = 16,
  parameter int SCL_W       = 8,
  parameter int IRQ_LINES   = 16,
  parameter int BASE_IRQ    = 6,
  parameter bit SEP_IRQ     = 1'b1,
  parameter bit FREEZE_FLAG = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 psel_i,
  input  logic                 penable_i,
  input  logic                 pwrite_i,
  input  logic [7:0]           paddr_i,
  input  logic [31:0]          pwdata_i,
  output logic [31:0]          prdata_o,
  output logic [IRQ_LINES-1:0] irq_o
);
  localparam int WD = (CNT_W > CTL_W) ? CNT_W : CTL_W;
  localparam logic [31:0] CFG_WORD =
    {22'b0, FREEZE_FLAG, SEP_IRQ, 5'(BASE_IRQ), 3'(N_TIMERS)};

  logic             wr;
  logic [3:0]       blk;
  logic [1:0]       rsel;
  logic             tick;
  logic [SCL_W-1:0] sval, srld;
  logic [CNT_W-1:0] cnt_a [N_TIMERS];
  logic [CNT_W-1:0] rld_a [N_TIMERS];
  logic [CTL_W-1:0] ctl_a [N_TIMERS];
  logic [N_TIMERS-1:0] evt, ip_vec;
  logic             unused_bits;

  assign wr          = psel_i && penable_i && pwrite_i;
  assign blk         = paddr_i[7:4];
  assign rsel        = paddr_i[3:2];
  assign unused_bits = ^{paddr_i[1:0], pwdata_i};

  tu_prescaler #(.SCL_W(SCL_W)) u_scaler (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .val_we_i (wr && blk == 4'd0 && rsel == GS_SVAL),
    .rld_we_i (wr && blk == 4'd0 && rsel == GS_SRLD),
    .wdata_i  (pwdata_i[SCL_W-1:0]),
    .val_o    (sval),
    .rld_o    (srld),
    .tick_o   (tick)
  );

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_chan
    logic hit;
    assign hit = wr && (blk == 4'(i + 1));
    tu_channel #(.CNT_W(CNT_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .cnt_we_i (hit && rsel == TS_CNT),
      .rld_we_i (hit && rsel == TS_RLD),
      .ctl_we_i (hit && rsel == TS_CTL),
      .wdata_i  (pwdata_i[WD-1:0]),
      .cnt_o    (cnt_a[i]),
      .rld_o    (rld_a[i]),
      .ctl_o    (ctl_a[i]),
      .irq_o    (evt[i])
    );
    assign ip_vec[i] = ctl_a[i][CB_IP];
  end

  tu_irq_route #(
    .N_TIMERS (N_TIMERS),
    .IRQ_LINES(IRQ_LINES),
    .BASE_IRQ (BASE_IRQ),
    .SEP_IRQ  (SEP_IRQ)
  ) u_route (
    .evt_i (evt),
    .irq_o (irq_o)
  );

  always_comb begin
    prdata_o = '0;
    if (blk == 4'd0) begin
      case (rsel)
        GS_SVAL: prdata_o = 32'(sval);
        GS_SRLD: prdata_o = 32'(srld);
        GS_CFG:  prdata_o = CFG_WORD;
        default: prdata_o = '0;
      endcase
    end else begin
      for (int i = 0; i < N_TIMERS; i++) begin
        if (blk == 4'(i + 1)) begin
          case (rsel)
            TS_CNT:  prdata_o = 32'(cnt_a[i]);
            TS_RLD:  prdata_o = 32'(rld_a[i]);
            TS_CTL:  prdata_o = 32'(ctl_a[i]);
            default: prdata_o = '0;
          endcase
        end
      end
    end
  end

  a_r8_irq_has_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> (|ip_vec));
  a_r8_shared_only_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!SEP_IRQ) |-> ((irq_o & ~(IRQ_LINES'(1) << BASE_IRQ)) == '0));
endmodule

// File: tb/mtimer_unit_test.sv
`timescale 1ns/1ps
module mtimer_unit_test;
  localparam int NT = 4;
  localparam int BASE = 6;
  localparam int MASK = 32'hFFFF;

  logic clk = 0, rst_ni = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = 0;
  logic [31:0] pwdata = 0;
  logic [31:0] prdata, prdata_sh;
  logic [15:0] irq, irq_sh;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mtimer_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
    .prdata_o(prdata), .irq_o(irq));

  mtimer_unit #(.SEP_IRQ(1'b0)) uut_sh (
    .clk_i(clk), .rst_ni(rst_ni), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
    .prdata_o(prdata_sh), .irq_o(irq_sh));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int sv, sr;
  int c[NT], r[NT];
  bit en[NT], rs[NT], ie[NT], ip[NT], ch[NT], dh[NT], pul[NT];

  always @(posedge clk) begin
    if (!rst_ni) begin
      sv = 0; sr = 0;
      for (int i = 0; i < NT; i++) begin
        c[i] = 0; r[i] = 0; en[i] = 0; rs[i] = 0; ie[i] = 0;
        ip[i] = 0; ch[i] = 0; dh[i] = 0; pul[i] = 0;
      end
    end else begin
      bit w, tk;
      int b, s, d;
      w = psel && penable && pwrite;
      b = paddr[7:4]; s = paddr[3:2]; d = pwdata;
      tk = (sv == 0);
      for (int i = 0; i < NT; i++) begin
        bit hit, cw, rw, kw, ld, uf;
        int nc;
        hit = w && (b == i + 1);
        cw = hit && s == 0; rw = hit && s == 1; kw = hit && s == 2;
        ld = kw && d[2];
        uf = tk && en[i] && c[i] == 0 && !cw && !ld;
        nc = c[i];
        if (cw) nc = d & MASK;
        else if (ld) nc = r[i];
        else if (tk && en[i]) nc = (c[i] != 0) ? c[i] - 1 : (rs[i] ? r[i] : 0);
        pul[i] = uf && ie[i];
        if (uf) ip[i] = 1;
        else if (kw && d[4]) ip[i] = 0;
        if (kw) begin
          en[i] = d[0]; rs[i] = d[1]; ie[i] = d[3]; ch[i] = d[5]; dh[i] = d[6];
        end else if (uf && !rs[i]) en[i] = 0;
        c[i] = nc;
        if (rw) r[i] = d & MASK;
      end
      if (w && b == 0 && s == 0) sv = d & 255;
      else if (sv == 0) sv = sr;
      else sv = sv - 1;
      if (w && b == 0 && s == 1) sr = d & 255;
    end
  end

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    int b, s;
    b = a[7:4]; s = a[3:2];
    if (b == 0) begin
      if (s == 0) return sv;
      if (s == 1) return sr;
      if (s == 2) return 32'h134;
      return 0;
    end
    if (b > NT) return 0;
    if (s == 0) return c[b-1];
    if (s == 1) return r[b-1];
    if (s == 2) return {25'b0, dh[b-1], ch[b-1], ip[b-1], ie[b-1], 1'b0, rs[b-1], en[b-1]};
    return 0;
  endfunction

  function automatic logic [15:0] exp_irq(bit shared);
    logic [15:0] v;
    v = 0;
    for (int i = 0; i < NT; i++) begin
      if (shared) v[BASE] = v[BASE] | pul[i];
      else v[BASE+i] = pul[i];
    end
    return v;
  endfunction

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk("R11 model read data", prdata, exp_rd(paddr));
      chk("R8 model separate lines", 32'(irq), 32'(exp_irq(0)));
      chk("R8 model shared line", 32'(irq_sh), 32'(exp_irq(1)));
    end
  end

  // pulse counters
  int pc[NT];
  int pc_sh = 0;
  initial for (int i = 0; i < NT; i++) pc[i] = 0;
  always @(posedge clk) begin
    if (rst_ni) begin
      for (int i = 0; i < NT; i++) if (irq[BASE+i]) pc[i]++;
      if (irq_sh[BASE]) pc_sh++;
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(posedge clk); #1;
    penable = 1;
    @(posedge clk); #1;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    paddr = a;
    @(negedge clk);
    d = prdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int s0, s1;
    repeat (3) @(posedge clk); #1;
    rst_ni = 1;

    // R1 reset state, R11 configuration word
    rd(8'h08, v); chk("R11 config word", v, 32'h134);
    v = prdata_sh; chk("R11 config shared flag", v, 32'h034);
    rd(8'h00, v); chk("R1 scaler value after reset", v, 0);
    rd(8'h04, v); chk("R1 scaler reload after reset", v, 0);
    rd(8'h18, v); chk("R1 control after reset", v, 0);
    rd(8'h14, v); chk("R1 reload after reset", v, 0);
    chk("R1 irq after reset", 32'(irq), 0);
    rd(8'h50, v); chk("R11 unmapped region", v, 0);

    // R9 width masking
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R9 counter mask", v, 32'hFFFF);
    wr(8'h14, 32'h0001_2345);
    rd(8'h14, v); chk("R9 reload mask", v, 32'h2345);

    // R10 readback, R6 load, R3 freeze
    wr(8'h18, 32'h6A);
    rd(8'h18, v); chk("R10 control readback", v, 32'h6A);
    wr(8'h18, 32'h6E);
    rd(8'h18, v); chk("R6 load reads zero", v, 32'h6A);
    rd(8'h10, v); chk("R6 load copies reload", v, 32'h2345);
    idle(20);
    rd(8'h10, v); chk("R3 disabled counter holds", v, 32'h2345);
    wr(8'h18, 32'h0);

    // R2 prescaler: tick every 4 clocks, timer3 period one tick
    wr(8'h04, 3);
    wr(8'h00, 3);
    wr(8'h44, 0);
    wr(8'h48, 32'h0F);
    idle(8);
    s0 = pc[3];
    idle(40);
    chk("R2 tick rate via timer pulses", pc[3] - s0, 10);
    wr(8'h48, 32'h10);

    // R4 periodic: reload 3 -> 16 clocks; R8 shared line count
    wr(8'h14, 3);
    wr(8'h18, 32'h0F);
    idle(8);
    s0 = pc[0]; s1 = pc_sh;
    idle(160);
    chk("R4 periodic pulse count", pc[0] - s0, 10);
    chk("R8 shared line pulse count", pc_sh - s1, 10);
    rd(8'h18, v); chk("R7 pending set by underflow", v & 32'h10, 32'h10);
    wr(8'h18, 32'h0);
    rd(8'h18, v); chk("R7 write zero keeps pending", v, 32'h10);
    wr(8'h18, 32'h10);
    rd(8'h18, v); chk("R7 write one clears pending", v, 32'h0);

    // R5 one-shot on timer1
    s0 = pc[1];
    wr(8'h24, 2);
    wr(8'h28, 32'h0D);
    idle(60);
    rd(8'h28, v); chk("R5 one-shot clears enable", v, 32'h18);
    rd(8'h20, v); chk("R5 one-shot counter at zero", v, 0);
    chk("R5 one-shot single pulse", pc[1] - s0, 1);

    // R8 interrupt enable gate on timer2
    s0 = pc[2];
    wr(8'h34, 1);
    wr(8'h38, 32'h07);
    idle(40);
    chk("R8 no pulse without enable", pc[2] - s0, 0);
    rd(8'h38, v); chk("R8 pending without enable", v, 32'h13);
    wr(8'h38, 32'h10);
    rd(8'h38, v); chk("R3 stopped timer control", v, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule